// File: doc/BRIEF.md
# Two-Wire Slave Address Matcher

This block looks at the first byte a two-wire bus target receives after a START or a repeated START. It compares the upper seven bits of that byte with a programmed device address. When enabled, it also checks whether the byte is the all-zero general-call address sent with the write direction. Bit shifting and bus timing belong to neighbouring logic. That logic delivers each received byte on a valid/ready stream and pulses `bus_start` for every START condition.

When an address byte hits, the block raises a notification on a second valid/ready stream. The notification carries which address matched and the direction bit. At the same time the block sets the level `ack_n` for the bus driver. It acknowledges the hit (drives `ack_n` low) only if `ack_en` is set when the byte is taken. Otherwise it releases SDA (`ack_n` high), so the device can decline its own address.

Back-pressure works as follows. A byte transfers on a clock edge where `in_valid` and `in_ready` are both high, and a notification transfers where `evt_valid` and `evt_ready` are both high. While a notification waits with `evt_ready` low, the block holds it unchanged and keeps `in_ready` low. Byte input is therefore paused until the notification is taken.

Top module: `addr_match_unit`

## Requirements
- R1: After reset, `evt_valid` is 0, `ack_n` is 1 (SDA released) and `in_ready` is 1.
- R2: The first byte taken after `bus_start` is the address byte. If its bits [7:1] equal `own_addr`, a notification follows with `evt_own`=1 and `evt_rw` equal to bit 0 of the byte (1 = read, 0 = write).
- R3: With `gc_en`=1, the address byte 8'h00 gives a notification with `evt_gc`=1 and `evt_rw`=0. With `gc_en`=0, or with the byte equal to 8'h01, `evt_gc` stays 0. A notification never has `evt_gc`=1 together with `evt_rw`=1.
- R4: One clock edge after a hitting address byte is taken, `ack_n` equals the inverse of `ack_en` as sampled at that edge.
- R5: An address byte that matches neither address gives no notification and sets `ack_n` to 1, whatever the value of `ack_en`.
- R6: Bytes taken after the address byte and before the next `bus_start` give no notification and do not change `ack_n`. The same holds for bytes taken after reset before any `bus_start`.
- R7: A `bus_start` pulse sets `ack_n` to 1 on the next edge and re-arms address detection.
- R8: While `evt_valid`=1 and `evt_ready`=0, the notification and its fields stay unchanged on the next cycle, and `in_ready` is 0.
- R9: A byte taken in the same cycle as `bus_start` is discarded. The next byte taken is the address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_start | input | 1 | One-cycle pulse for each START or repeated START |
| in_valid | input | 1 | Received byte is valid |
| in_ready | output | 1 | Block can take a byte |
| in_data | input | ADDR_W+1 | Received byte; bit 0 is the direction |
| own_addr | input | ADDR_W | Programmed device address |
| gc_en | input | 1 | Enable general-call recognition |
| ack_en | input | 1 | Acknowledge a matched address when 1 |
| evt_valid | output | 1 | Match notification valid |
| evt_ready | input | 1 | Control logic takes the notification |
| evt_own | output | 1 | Notification: own address matched |
| evt_gc | output | 1 | Notification: general call matched |
| evt_rw | output | 1 | Notification: direction bit of the address byte |
| ack_n | output | 1 | Acknowledge bit to drive: 0 = ACK, 1 = NACK |

## Verification
The bench builds the block with the default `ADDR_W` of 7. It reprograms `own_addr` between frames, which exercises an all-ones address, a mixed pattern, and an all-zero address that overlaps the general call. At this width, 8'h00 and 8'h01 can be sent to separate the general-call write from a read. With a narrow address, bytes that differ from the device address in a single bit can also be sent. Holding `evt_ready` low during a frame exercises the stall path, which blocks a following byte.

// File: rtl/amu_pkg.sv
package amu_pkg;
  typedef struct packed {
    logic own;
    logic gc;
    logic rw;
  } amu_hit_t;
endpackage

// File: rtl/amu_phase.sv
module amu_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_start,
  input  logic byte_fire,
  output logic addr_fire
);
  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n)          armed <= 1'b0;
    else if (bus_start)  armed <= 1'b1;
    else if (byte_fire)  armed <= 1'b0;
  end

  // a byte coinciding with a start belongs to no frame
  assign addr_fire = byte_fire & armed & ~bus_start;

  AST_ADDR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_fire |=> !addr_fire); // R6
endmodule

// File: rtl/amu_compare.sv
module amu_compare
  import amu_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W:0]   byte_in,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  output amu_hit_t          hit
);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  logic [ADDR_W-1:0] own_eq;
  logic [ADDR_W-1:0] gc_eq;

  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign own_eq[i] = ~(byte_in[i+1] ^ own_addr[i]);
    assign gc_eq[i]  = ~(byte_in[i+1] ^ GC_ADDR[i]);
  end

  always_comb begin
    hit.rw  = byte_in[0];
    hit.own = &own_eq;
    hit.gc  = gc_en & (&gc_eq) & ~byte_in[0];
  end
endmodule

// File: rtl/amu_evt_reg.sv
module amu_evt_reg
  import amu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_start,
  input  logic     load,
  input  amu_hit_t hit,
  input  logic     ack_en,
  input  logic     evt_ready,
  output logic     evt_valid,
  output amu_hit_t evt,
  output logic     ack_n,
  output logic     in_ready
);
  logic any_hit;
  assign any_hit  = hit.own | hit.gc;
  assign in_ready = ~evt_valid | evt_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid <= 1'b0;
      evt       <= '0;
    end else if (load && any_hit) begin
      evt_valid <= 1'b1;
      evt       <= hit;
    end else if (evt_ready) begin
      evt_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         ack_n <= 1'b1;
    else if (bus_start) ack_n <= 1'b1;
    else if (load)      ack_n <= ~(any_hit & ack_en);
  end

  AST_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt))); // R8
  AST_ACK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(ack_en)); // R4
  AST_START_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> ack_n); // R7
endmodule

// File: rtl/addr_match_unit.sv
module addr_match_unit
  import amu_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W:0]   in_data,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  output logic              evt_valid,
  input  logic              evt_ready,
  output logic              evt_own,
  output logic              evt_gc,
  output logic              evt_rw,
  output logic              ack_n
);
  logic     byte_fire;
  logic     addr_fire;
  amu_hit_t hit;
  amu_hit_t evt;

  assign byte_fire = in_valid & in_ready;

  amu_phase u_phase (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .byte_fire (byte_fire),
    .addr_fire (addr_fire)
  );

  amu_compare #(.ADDR_W(ADDR_W)) u_cmp (
    .byte_in  (in_data),
    .own_addr (own_addr),
    .gc_en    (gc_en),
    .hit      (hit)
  );

  amu_evt_reg u_evt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .load      (addr_fire),
    .hit       (hit),
    .ack_en    (ack_en),
    .evt_ready (evt_ready),
    .evt_valid (evt_valid),
    .evt       (evt),
    .ack_n     (ack_n),
    .in_ready  (in_ready)
  );

  assign evt_own = evt.own;
  assign evt_gc  = evt.gc;
  assign evt_rw  = evt.rw;

  AST_EVT_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> (evt_own || evt_gc)); // R5
  AST_GC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_gc) |-> !evt_rw); // R3
  AST_NEW_EVT_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && $past(!byte_fire)) |=> !evt_valid || $past(addr_fire)); // R6
endmodule

// File: tb/addr_match_unit_bench.sv
module addr_match_unit_bench;
  localparam int AW = 7;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          bus_start = 0;
  logic          in_valid = 0;
  logic          in_ready;
  logic [AW:0]   in_data = '0;
  logic [AW-1:0] own_addr = '0;
  logic          gc_en = 0;
  logic          ack_en = 0;
  logic          evt_valid;
  logic          evt_ready = 1;
  logic          evt_own, evt_gc, evt_rw;
  logic          ack_n;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [2:0] expq[$];

  always #5 clk = ~clk;

  addr_match_unit #(.ADDR_W(AW)) u_addr_match_unit (
    .clk(clk), .rst_n(rst_n), .bus_start(bus_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .own_addr(own_addr), .gc_en(gc_en), .ack_en(ack_en),
    .evt_valid(evt_valid), .evt_ready(evt_ready),
    .evt_own(evt_own), .evt_gc(evt_gc), .evt_rw(evt_rw), .ack_n(ack_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each notification handshake
  always @(negedge clk) begin
    if (rst_n && evt_valid && evt_ready) begin
      if (expq.size() == 0) begin
        chk(0, "R5/R6 unexpected notification", {evt_own, evt_gc, evt_rw}, 0);
      end else begin
        logic [2:0] e;
        e = expq.pop_front();
        chk({evt_own, evt_gc, evt_rw} == e, "R2/R3 notification fields",
            {evt_own, evt_gc, evt_rw}, e);
      end
    end
  end

  task automatic start_pulse();
    @(posedge clk); #2 bus_start = 1;
    @(posedge clk); #2 bus_start = 0;
  endtask

  task automatic send_byte(input logic [AW:0] b);
    @(posedge clk); #2 in_valid = 1; in_data = b;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #2 in_valid = 0;
  endtask

  // address byte with scoreboard push and ack check (R2 R3 R4 R5)
  task automatic addr_frame(input logic [AW:0] b, input string tag);
    bit o, g, h;
    o = (b[AW:1] == own_addr);
    g = gc_en && (b == '0);
    h = o || g;
    start_pulse();
    if (h) expq.push_back({o, g, b[0]});
    send_byte(b);
    @(negedge clk);
    chk(ack_n == !(h && ack_en), tag, ack_n, !(h && ack_en));
  endtask

  task automatic drained(input string tag);
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, tag, expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    chk(!evt_valid && ack_n && in_ready, "R1 reset state",
        {evt_valid, ack_n, in_ready}, 3'b011);

    own_addr = 7'h5A; ack_en = 1;
    send_byte({7'h5A, 1'b0});            // before any start
    drained("R6 byte before start ignored");
    chk(ack_n == 1, "R6 ack unchanged before start", ack_n, 1);

    addr_frame({7'h5A, 1'b0}, "R2 own write ack");
    addr_frame({7'h5A, 1'b1}, "R2 own read ack");
    drained("R2 events drained");

    send_byte({7'h5A, 1'b1});            // data byte
    drained("R6 data byte no notification");
    chk(ack_n == 0, "R6 data byte keeps ack", ack_n, 0);

    ack_en = 0;
    addr_frame({7'h5A, 1'b0}, "R4 own match declined");
    ack_en = 1;
    addr_frame({7'h5B, 1'b0}, "R5 mismatch nack");
    addr_frame({7'h1A, 1'b0}, "R5 one-bit-off nack");
    drained("R5 no event on mismatch");

    gc_en = 0;
    addr_frame(8'h00, "R3 gc disabled nack");
    gc_en = 1;
    addr_frame(8'h00, "R3 gc write ack");
    addr_frame(8'h01, "R3 gc read not matched");
    own_addr = 7'h00;
    addr_frame(8'h00, "R3 own zero plus gc");
    own_addr = 7'h7F;
    addr_frame(8'hFF, "R2 all-ones read");
    drained("R3 events drained");

    start_pulse();
    @(negedge clk);
    chk(ack_n == 1, "R7 start releases ack", ack_n, 1);

    // R9: byte concurrent with start is discarded
    own_addr = 7'h33;
    @(posedge clk); #2 bus_start = 1; in_valid = 1; in_data = {7'h33, 1'b0};
    @(posedge clk); #2 bus_start = 0; in_valid = 0;
    drained("R9 concurrent byte discarded");
    chk(ack_n == 1, "R9 ack untouched", ack_n, 1);
    expq.push_back({1'b1, 1'b0, 1'b1});
    send_byte({7'h33, 1'b1});
    drained("R9 next byte is address");

    // R8: back-pressure
    evt_ready = 0;
    start_pulse();
    expq.push_back({1'b1, 1'b0, 1'b0});
    send_byte({7'h33, 1'b0});
    repeat (3) @(negedge clk);
    chk(evt_valid && evt_own && !evt_rw, "R8 held notification",
        {evt_valid, evt_own, evt_rw}, 3'b110);
    chk(in_ready == 0, "R8 input stalled", in_ready, 0);
    @(posedge clk); #2 evt_ready = 1;
    drained("R8 released");
    chk(!evt_valid && in_ready, "R8 idle after release", {evt_valid, in_ready}, 2'b01);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) chk(0, "watchdog expired", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule